// File: doc/BRIEF.md
# Crystal Multiplicity Trigger Unit

The unit watches hit strobes and energy estimates from an array of detector crystals on one common clock. From them it forms a trigger decision based on how many crystals fired. A crystal qualifies for the count when its energy lies between a lower threshold and an upper ceiling. Crystals above the ceiling are treated as charged-particle hits and are left out. The first qualifying hit opens a coincidence window of programmable length. When the window closes, the collected set of crystals is judged in one of three ways, picked by a mode field:
- a plain multiplicity test;
- a two-level test, which counts at the qualifying threshold but reads out every crystal above a separate readout threshold;
- a pattern test, which compares the front-group and back-group counts against their own minima and joins the two results with AND or OR.

An issued trigger gives a one-cycle pulse together with a crystal readout mask, the condition code and the timestamp of the deciding cycle. A free-running timestamp can be cleared synchronously. A raw counter records every satisfied condition. An accepted counter records only issued triggers. A programmable hold-off after each issued trigger suppresses further pulses, but satisfied conditions during it still reach the raw counter.

Top module: `mult_trig_unit`

## Requirements
- R1: A crystal qualifies when its strobe is high and its energy is at or above `cfg_thr_count` and at or below `cfg_thr_ceiling`. Only qualifying hits open a window or count toward multiplicity.
- R2: A crystal whose energy exceeds `cfg_thr_ceiling` is excluded from every multiplicity count, and from the mask in modes 1 and 3.
- R3: A qualifying hit with no window open starts a window that collects hits on that cycle and the next `cfg_window` cycles. The decision is taken on the following edge, so `trig_pulse` is high for one cycle, exactly `cfg_window`+1 cycles after the opening edge. A hit arriving on the deciding edge belongs to the next window.
- R4: Mode 1 (simple) fires when the qualifying count is at least `cfg_mult_min`. It sets `trig_code` to 2'b01 and `trig_mask` to the qualifying crystals.
- R5: Mode 2 (two-level) fires on the same count test as mode 1 and sets `trig_code` to 2'b10. `trig_mask` then holds every crystal that struck with energy at or above `cfg_thr_readout` while the window was open, whether or not it was vetoed.
- R6: Mode 3 (pattern) counts qualifying crystals whose `cfg_front_map` bit is 1 as front and all others as back. Each group count is compared with its own minimum, and the two results are ANDed when `cfg_pattern_and` is 1 and ORed when it is 0. `trig_code` is 2'b11 and `trig_mask` holds the qualifying crystals.
- R7: Mode 0 never fires a trigger and never advances either counter.
- R8: `trig_time` holds the timestamp value of the cycle on which the issuing condition was met. The timestamp advances by one on every clock edge.
- R9: After an issued trigger, no further trigger issues until `cfg_holdoff` edges have passed. A condition met during the hold-off advances `raw_count` only.
- R10: `raw_count` advances by one for each window decision whose condition is met. `acc_count` advances by one for each `trig_pulse`.
- R11: After reset, the pulse, the mask, the code, the time and both counters are zero.
- R12: `ts_clear` sets the timestamp to zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_clear | input | 1 | Synchronous timestamp clear |
| hit_valid | input | N_CRYS | Per-crystal hit strobe |
| hit_energy | input | N_CRYS*E_W | Per-crystal energy, crystal i at bits i*E_W upward |
| cfg_mode | input | 2 | 0 off, 1 simple, 2 two-level, 3 pattern |
| cfg_thr_count | input | E_W | Lower threshold for multiplicity |
| cfg_thr_ceiling | input | E_W | Upper veto ceiling |
| cfg_thr_readout | input | E_W | Readout threshold for two-level mode |
| cfg_mult_min | input | CNT_W | Minimum multiplicity, modes 1 and 2 |
| cfg_front_min | input | CNT_W | Minimum front-group count |
| cfg_back_min | input | CNT_W | Minimum back-group count |
| cfg_pattern_and | input | 1 | 1 joins group tests with AND, 0 with OR |
| cfg_front_map | input | N_CRYS | 1 marks a crystal as front group |
| cfg_window | input | WIN_W | Extra window cycles after the opening cycle |
| cfg_holdoff | input | HOLD_W | Hold-off length in cycles |
| trig_pulse | output | 1 | One-cycle trigger strobe |
| trig_mask | output | N_CRYS | Readout mask of the last trigger |
| trig_code | output | 2 | Condition code of the last trigger |
| trig_time | output | TS_W | Timestamp of the last trigger |
| raw_count | output | CTR_W | Satisfied-condition counter |
| acc_count | output | CTR_W | Issued-trigger counter |

## Verification
The bench builds the unit with eight crystals, 12-bit energies, 16-bit counters and a front map that marks the lower four crystals. This puts every grouping and mask value into a single readable byte. Windows of zero and three extra cycles make the exact window edge, a hit on the deciding edge and the hold-off release cycle reachable within a few clocks. A 48-bit timestamp is kept so that the recorded time can be compared exactly with a cycle count taken in the bench.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  typedef enum logic [1:0] {
    MODE_OFF       = 2'd0,
    MODE_SIMPLE    = 2'd1,
    MODE_TWO_LEVEL = 2'd2,
    MODE_PATTERN   = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/mtu_qualify.sv
module mtu_qualify #(
  parameter int N_CRYS = 120,
  parameter int E_W    = 16
) (
  input  logic [N_CRYS-1:0]     hit_valid,
  input  logic [N_CRYS*E_W-1:0] hit_energy,
  input  logic [E_W-1:0]        thr_count,
  input  logic [E_W-1:0]        thr_ceiling,
  input  logic [E_W-1:0]        thr_readout,
  output logic [N_CRYS-1:0]     qual_hit,
  output logic [N_CRYS-1:0]     ro_hit
);
  function automatic logic in_band(input logic [E_W-1:0] e,
                                   input logic [E_W-1:0] lo,
                                   input logic [E_W-1:0] hi);
    return (e >= lo) && (e <= hi);
  endfunction

  for (genvar i = 0; i < N_CRYS; i++) begin : g_crys
    logic [E_W-1:0] energy;
    assign energy      = hit_energy[i*E_W +: E_W];
    assign qual_hit[i] = hit_valid[i] && in_band(energy, thr_count, thr_ceiling);
    assign ro_hit[i]   = hit_valid[i] && (energy >= thr_readout);
  end
endmodule

// File: rtl/mtu_window.sv
module mtu_window #(
  parameter int N_CRYS = 120,
  parameter int WIN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CRYS-1:0] qual_hit,
  input  logic [N_CRYS-1:0] ro_hit,
  input  logic [WIN_W-1:0]  win_len,
  output logic              eval_now,
  output logic [N_CRYS-1:0] qual_set,
  output logic [N_CRYS-1:0] ro_set
);
  logic             win_act;
  logic [WIN_W-1:0] wcnt;
  logic             open_req;

  assign open_req = |qual_hit;
  assign eval_now = win_act && (wcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_act  <= 1'b0;
      wcnt     <= '0;
      qual_set <= '0;
      ro_set   <= '0;
    end else if (!win_act || eval_now) begin
      win_act  <= open_req;
      wcnt     <= win_len;
      qual_set <= qual_hit;
      ro_set   <= open_req ? ro_hit : '0;
    end else begin
      wcnt     <= wcnt - WIN_W'(1);
      qual_set <= qual_set | qual_hit;
      ro_set   <= ro_set | ro_hit;
    end
  end

  assert_window_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eval_now |-> (|qual_set));

  assert_window_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act && wcnt != '0) |=> (win_act && wcnt == $past(wcnt) - WIN_W'(1)));
endmodule

// File: rtl/mtu_decide.sv
module mtu_decide
  import mtu_pkg::*;
#(
  parameter int N_CRYS = 120,
  parameter int CNT_W  = 7
) (
  input  logic [N_CRYS-1:0] qual_set,
  input  logic [N_CRYS-1:0] ro_set,
  input  logic [N_CRYS-1:0] front_map,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  mult_min,
  input  logic [CNT_W-1:0]  front_min,
  input  logic [CNT_W-1:0]  back_min,
  input  logic              pattern_and,
  output logic              cond_met,
  output logic [1:0]        cond_code,
  output logic [N_CRYS-1:0] sel_mask
);
  function automatic logic [CNT_W-1:0] pop(input logic [N_CRYS-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < N_CRYS; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  logic [CNT_W-1:0] mult_all, mult_front, mult_back;
  logic             mult_ok, front_ok, back_ok, pattern_ok;

  assign mult_all   = pop(qual_set);
  assign mult_front = pop(qual_set & front_map);
  assign mult_back  = pop(qual_set & ~front_map);
  assign mult_ok    = mult_all >= mult_min;
  assign front_ok   = mult_front >= front_min;
  assign back_ok    = mult_back >= back_min;
  assign pattern_ok = pattern_and ? (front_ok && back_ok) : (front_ok || back_ok);

  always_comb begin
    cond_met  = 1'b0;
    cond_code = mode;
    sel_mask  = qual_set;
    case (trig_mode_e'(mode))
      MODE_SIMPLE:    cond_met = mult_ok;
      MODE_TWO_LEVEL: begin
        cond_met = mult_ok;
        sel_mask = ro_set;
      end
      MODE_PATTERN:   cond_met = pattern_ok;
      default:        cond_met = 1'b0;
    endcase
  end
endmodule

// File: rtl/mult_trig_unit.sv
module mult_trig_unit #(
  parameter int N_CRYS = 120,
  parameter int E_W    = 16,
  parameter int WIN_W  = 6,
  parameter int HOLD_W = 16,
  parameter int TS_W   = 48,
  parameter int CTR_W  = 32,
  localparam int CNT_W = $clog2(N_CRYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ts_clear,
  input  logic [N_CRYS-1:0]     hit_valid,
  input  logic [N_CRYS*E_W-1:0] hit_energy,
  input  logic [1:0]            cfg_mode,
  input  logic [E_W-1:0]        cfg_thr_count,
  input  logic [E_W-1:0]        cfg_thr_ceiling,
  input  logic [E_W-1:0]        cfg_thr_readout,
  input  logic [CNT_W-1:0]      cfg_mult_min,
  input  logic [CNT_W-1:0]      cfg_front_min,
  input  logic [CNT_W-1:0]      cfg_back_min,
  input  logic                  cfg_pattern_and,
  input  logic [N_CRYS-1:0]     cfg_front_map,
  input  logic [WIN_W-1:0]      cfg_window,
  input  logic [HOLD_W-1:0]     cfg_holdoff,
  output logic                  trig_pulse,
  output logic [N_CRYS-1:0]     trig_mask,
  output logic [1:0]            trig_code,
  output logic [TS_W-1:0]       trig_time,
  output logic [CTR_W-1:0]      raw_count,
  output logic [CTR_W-1:0]      acc_count
);
  logic [N_CRYS-1:0] qual_hit, ro_hit, qual_set, ro_set, sel_mask;
  logic              eval_now, cond_met, fire_raw, issue;
  logic [1:0]        cond_code;
  logic [HOLD_W-1:0] hold_cnt;
  logic [TS_W-1:0]   ts_now;

  mtu_qualify #(.N_CRYS(N_CRYS), .E_W(E_W)) u_qualify (
    .hit_valid(hit_valid), .hit_energy(hit_energy),
    .thr_count(cfg_thr_count), .thr_ceiling(cfg_thr_ceiling),
    .thr_readout(cfg_thr_readout),
    .qual_hit(qual_hit), .ro_hit(ro_hit)
  );

  mtu_window #(.N_CRYS(N_CRYS), .WIN_W(WIN_W)) u_window (
    .clk(clk), .rst_n(rst_n), .qual_hit(qual_hit), .ro_hit(ro_hit),
    .win_len(cfg_window), .eval_now(eval_now),
    .qual_set(qual_set), .ro_set(ro_set)
  );

  mtu_decide #(.N_CRYS(N_CRYS), .CNT_W(CNT_W)) u_decide (
    .qual_set(qual_set), .ro_set(ro_set), .front_map(cfg_front_map),
    .mode(cfg_mode), .mult_min(cfg_mult_min), .front_min(cfg_front_min),
    .back_min(cfg_back_min), .pattern_and(cfg_pattern_and),
    .cond_met(cond_met), .cond_code(cond_code), .sel_mask(sel_mask)
  );

  assign fire_raw = eval_now && cond_met;
  assign issue    = fire_raw && (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_now     <= '0;
      trig_pulse <= 1'b0;
      trig_mask  <= '0;
      trig_code  <= '0;
      trig_time  <= '0;
      hold_cnt   <= '0;
      raw_count  <= '0;
      acc_count  <= '0;
    end else begin
      ts_now     <= ts_clear ? '0 : ts_now + TS_W'(1);
      trig_pulse <= issue;
      if (issue) begin
        trig_mask <= sel_mask;
        trig_code <= cond_code;
        trig_time <= ts_now;
        hold_cnt  <= cfg_holdoff;
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - HOLD_W'(1);
      end
      if (fire_raw) raw_count <= raw_count + CTR_W'(1);
      if (issue)    acc_count <= acc_count + CTR_W'(1);
    end
  end

  assert_acc_follows_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (acc_count == $past(acc_count) + CTR_W'(1)));

  assert_raw_follows_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (raw_count == $past(raw_count) + CTR_W'(1)));

  assert_code_not_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (trig_code != 2'b00));

  assert_holdoff_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != '0) |=> !trig_pulse);

  assert_ts_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clear |=> (ts_now == '0));
endmodule

// File: tb/test_mult_trig_unit.sv
`timescale 1ns/1ps
module test_mult_trig_unit;
  localparam int N = 8, E_W = 12, WIN_W = 6, HOLD_W = 8, TS_W = 48, CTR_W = 16;
  localparam int CNT_W = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0, ts_clear = 1'b0;
  logic [N-1:0]     hv = '0;
  logic [N*E_W-1:0] he = '0;
  logic [1:0]       mode = 2'd1;
  logic [E_W-1:0]   thr_lo = 12'd100, thr_hi = 12'd3000, thr_ro = 12'd50;
  logic [CNT_W-1:0] mult_min = 4'd2, front_min = 4'd2, back_min = 4'd1;
  logic             pat_and = 1'b1;
  logic [N-1:0]     front_map = 8'h0F;
  logic [WIN_W-1:0] win = 6'd3;
  logic [HOLD_W-1:0] holdoff = '0;
  logic             trig_pulse;
  logic [N-1:0]     trig_mask;
  logic [1:0]       trig_code;
  logic [TS_W-1:0]  trig_time;
  logic [CTR_W-1:0] raw_count, acc_count;

  int n_tests = 0, n_fail = 0, npulse = 0;
  longint cyc = 0;
  logic [CTR_W-1:0] raw0, acc0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mult_trig_unit #(.N_CRYS(N), .E_W(E_W), .WIN_W(WIN_W), .HOLD_W(HOLD_W),
                   .TS_W(TS_W), .CTR_W(CTR_W)) i_mult_trig_unit (
    .clk(clk), .rst_n(rst_n), .ts_clear(ts_clear), .hit_valid(hv), .hit_energy(he),
    .cfg_mode(mode), .cfg_thr_count(thr_lo), .cfg_thr_ceiling(thr_hi),
    .cfg_thr_readout(thr_ro), .cfg_mult_min(mult_min), .cfg_front_min(front_min),
    .cfg_back_min(back_min), .cfg_pattern_and(pat_and), .cfg_front_map(front_map),
    .cfg_window(win), .cfg_holdoff(holdoff), .trig_pulse(trig_pulse),
    .trig_mask(trig_mask), .trig_code(trig_code), .trig_time(trig_time),
    .raw_count(raw_count), .acc_count(acc_count)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input int e);
    hv[idx] = 1'b1;
    he[idx*E_W +: E_W] = E_W'(e);
  endtask

  task automatic step();
    @(negedge clk);
    if (trig_pulse) npulse++;
    hv = '0;
    he = '0;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic mark();
    steps(8);
    raw0 = raw_count;
    acc0 = acc_count;
    npulse = 0;
  endtask

  task automatic t_reset();
    check(trig_pulse == 1'b0, "R11 pulse", trig_pulse, 0);
    check(trig_mask == '0, "R11 mask", trig_mask, 0);
    check(trig_code == '0, "R11 code", trig_code, 0);
    check(trig_time == '0, "R11 time", trig_time, 0);
    check(raw_count == '0 && acc_count == '0, "R11 counters", raw_count + acc_count, 0);
  endtask

  task automatic t_simple();
    mode = 2'd1; win = 6'd3; mult_min = 4'd2; mark();
    put(0, 100); step();
    step();
    put(5, 500); step();
    put(6, 99);  step();
    check(trig_pulse == 1'b0, "R3 no early pulse", trig_pulse, 0);
    step();
    check(trig_pulse == 1'b1, "R3 pulse at window end", trig_pulse, 1);
    check(trig_mask == 8'h21, "R1 R4 mask", trig_mask, 8'h21);
    check(trig_code == 2'b01, "R4 code", trig_code, 1);
    check(raw_count == raw0 + 1 && acc_count == acc0 + 1, "R10 counters", raw_count, raw0 + 1);
    step();
    check(trig_pulse == 1'b0, "R3 one-cycle pulse", trig_pulse, 0);
  endtask

  task automatic t_late_hit();
    mode = 2'd1; win = 6'd3; mult_min = 4'd2; mark();
    put(1, 300); step();
    steps(3);
    put(2, 300); step();
    steps(6);
    check(npulse == 0, "R3 hit on deciding edge not counted", npulse, 0);
    check(raw_count == raw0, "R3 raw unchanged", raw_count, raw0);
  endtask

  task automatic t_veto();
    mode = 2'd1; win = 6'd3; mult_min = 4'd2; mark();
    put(0, 3001); put(1, 3000); step();
    steps(6);
    check(npulse == 0, "R2 vetoed crystal not counted", npulse, 0);
    mark();
    put(0, 3001); put(1, 3000); put(2, 150); step();
    steps(3);
    step();
    check(trig_pulse == 1'b1, "R2 pulse", trig_pulse, 1);
    check(trig_mask == 8'h06, "R2 mask excludes vetoed", trig_mask, 8'h06);
  endtask

  task automatic t_two_level();
    mode = 2'd2; win = 6'd3; mult_min = 4'd2; thr_ro = 12'd50; mark();
    put(0, 60); put(1, 150); put(2, 4000); put(3, 200); step();
    steps(3);
    step();
    check(trig_pulse == 1'b1, "R5 pulse", trig_pulse, 1);
    check(trig_mask == 8'h0F, "R5 readout mask", trig_mask, 8'h0F);
    check(trig_code == 2'b10, "R5 code", trig_code, 2);
  endtask

  task automatic t_pattern();
    mode = 2'd3; win = 6'd3; front_min = 4'd2; back_min = 4'd1; pat_and = 1'b1; mark();
    put(0, 200); put(1, 200); step();
    steps(6);
    check(npulse == 0 && raw_count == raw0, "R6 AND needs back", npulse, 0);
    mark();
    put(0, 200); put(1, 200); step();
    put(4, 200); step();
    steps(2);
    step();
    check(trig_pulse == 1'b1, "R6 AND fires", trig_pulse, 1);
    check(trig_mask == 8'h13 && trig_code == 2'b11, "R6 mask code", trig_mask, 8'h13);
    pat_and = 1'b0; mark();
    put(4, 200); step();
    steps(3);
    step();
    check(trig_pulse == 1'b1 && trig_mask == 8'h10, "R6 OR back only", trig_mask, 8'h10);
    back_min = 4'd3; mark();
    put(4, 200); step();
    steps(6);
    check(npulse == 0, "R6 OR neither group", npulse, 0);
    back_min = 4'd1;
  endtask

  task automatic t_mode_off();
    mode = 2'd0; win = 6'd3; mult_min = 4'd1; mark();
    put(0, 200); put(1, 200); put(4, 200); put(5, 200); step();
    steps(8);
    check(npulse == 0, "R7 no pulse", npulse, 0);
    check(raw_count == raw0 && acc_count == acc0, "R7 counters still", raw_count, raw0);
  endtask

  task automatic t_holdoff();
    mode = 2'd1; win = 6'd0; mult_min = 4'd1; holdoff = 8'd10; mark();
    put(0, 200); step();
    step();
    check(trig_pulse == 1'b1, "R9 first pulse", trig_pulse, 1);
    npulse = 0;
    steps(8);
    put(0, 200); step();
    put(1, 200); step();
    check(trig_pulse == 1'b0 && npulse == 0, "R9 suppressed in hold-off", trig_pulse, 0);
    step();
    check(trig_pulse == 1'b1, "R9 release cycle", trig_pulse, 1);
    check(trig_mask == 8'h02, "R9 mask after release", trig_mask, 8'h02);
    check(raw_count == raw0 + 3, "R9 raw counts suppressed", raw_count, raw0 + 3);
    check(acc_count == acc0 + 2, "R9 acc skips suppressed", acc_count, acc0 + 2);
    holdoff = '0;
  endtask

  task automatic t_timestamp();
    longint cc, ce, t1;
    mode = 2'd1; win = 6'd3; mult_min = 4'd1; mark();
    ts_clear = 1'b1; step(); ts_clear = 1'b0;
    cc = cyc;
    steps(5);
    put(3, 200); step();
    steps(3);
    step();
    ce = cyc;
    check(trig_pulse == 1'b1, "R8 pulse", trig_pulse, 1);
    check(trig_time == TS_W'(ce - cc - 1), "R12 R8 time after clear", trig_time, ce - cc - 1);
    t1 = longint'(trig_time);
    steps(20);
    put(3, 200); step();
    steps(3);
    step();
    check(longint'(trig_time) - t1 == cyc - ce, "R8 time spacing", longint'(trig_time) - t1, cyc - ce);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    steps(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_simple();
    t_late_hit();
    t_veto();
    t_two_level();
    t_pattern();
    t_mode_off();
    t_holdoff();
    t_timestamp();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule